// File: doc/BRIEF.md
# Slave-Select / GPIO Pin Controller

This block owns four pins. Each pin is set on its own to one of two roles: a chip select for the SPI master, or a general-purpose I/O. After reset every pin is a chip select. A command front-end passes decoded function IDs to the block along with one data byte. Four IDs are handled here: choose the role of each pin, set its electrical type, set its output level, and take a snapshot of the pin states.

The block does not return a snapshot on the command path. It writes the snapshot into byte 0 of the shared data buffer. The host then fetches that byte with an ordinary one-byte buffer read, so reading pin states always takes two messages. For each pin the block drives an output value and an output enable, and it asks for a pull-up or pull-down. The pad itself lies outside the block.

Top module: `ssg_pin_ctrl`

## Requirements
- R1: After synchronous reset all pins are chip selects. The role mask, the type codes and the output levels are all 0. Every pin has oe=1, pu=0 and pd=0, and its output equals the SPI select input for that pin.
- R2: Function F6h loads data bits 3:0 into the role mask. Bit i=1 makes pin i a GPIO and bit i=0 makes it a chip select.
- R3: Function F7h loads the per-pin type codes. Pin i takes data bits [2i+1:2i], so bits 7:6 belong to pin 3 and bits 1:0 to pin 0.
- R4: A GPIO pin behaves according to its type code, where L is its output level:
  - 00 (bidirectional): out=L, oe=!L, pu=1, pd=0.
  - 01 (input): out=0, oe=0, pu=0, pd=0.
  - 10 (output with pull-up): out=L, oe=1, pu=1, pd=0.
  - 11 (output with pull-down): out=L, oe=1, pu=0, pd=1.
- R5: Function F4h loads data bits 3:0 into the output levels. A level shows on a pin only while that pin is a GPIO.
- R6: A chip-select pin passes the SPI select input straight through to its output, with oe=1 and no pull.
- R7: Function F5h causes exactly one buffer write, in the cycle after the command. The write goes to address 0. Its data is the pin inputs sampled in the command cycle, with bits forced to 0 for chip-select pins and bits 7:4 also 0.
- R8: Each accepted F4h, F5h, F6h or F7h raises cmd_done for exactly one cycle, in the cycle after the command.
- R9: Any other function ID leaves all registers and pins unchanged, gives no cmd_done and makes no buffer write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_func | input | 8 | Function ID |
| cmd_data | input | 8 | Data byte that goes with the function |
| cmd_done | output | 1 | One-cycle completion pulse |
| spi_sel_n | input | NUM_PINS | Select outputs of the SPI master |
| pin_in | input | NUM_PINS | Sampled pad levels |
| pin_out | output | NUM_PINS | Pad output value |
| pin_oe | output | NUM_PINS | Pad output enable |
| pin_pu | output | NUM_PINS | Pull-up request |
| pin_pd | output | NUM_PINS | Pull-down request |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wr_addr | output | BUF_AW | Buffer write address |
| buf_wr_data | output | 8 | Buffer write data |

## Verification
Suppose the role mask, type codes or levels held a wrong value. Pin outputs are combinational from these registers, so the error would show on pin_out, pin_oe, pin_pu or pin_pd in the first cycle after the command that loaded the register. The bench checks all four vectors after every command, against a model of its own. A wrong role mask would also show in the next F5h snapshot: it would mask the wrong bits of the buffer byte. A fault in the done or write sequencing shows up one cycle after the command, as a missing, extra or mismatched item on the scoreboard.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

    localparam logic [7:0] FID_LEVEL  = 8'hF4;
    localparam logic [7:0] FID_SNAP   = 8'hF5;
    localparam logic [7:0] FID_ROLE   = 8'hF6;
    localparam logic [7:0] FID_TYPE   = 8'hF7;
    localparam int         BYTE_W     = 8;

    typedef enum logic [1:0] {
        PT_BIDIR  = 2'b00,
        PT_INPUT  = 2'b01,
        PT_OUT_PU = 2'b10,
        PT_OUT_PD = 2'b11
    } pin_type_e;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_LEVEL = 3'd1,
        OP_SNAP  = 3'd2,
        OP_ROLE  = 3'd3,
        OP_TYPE  = 3'd4
    } pin_op_e;

    typedef struct packed {
        logic out;
        logic oe;
        logic pu;
        logic pd;
    } pin_drive_t;

    function automatic pin_op_e decode_func(input logic valid, input logic [7:0] fid);
        pin_op_e op;
        op = OP_NONE;
        if (valid) begin
            case (fid)
                FID_LEVEL: op = OP_LEVEL;
                FID_SNAP:  op = OP_SNAP;
                FID_ROLE:  op = OP_ROLE;
                FID_TYPE:  op = OP_TYPE;
                default:   op = OP_NONE;
            endcase
        end
        return op;
    endfunction

    function automatic pin_drive_t gpio_drive(input pin_type_e t, input logic lvl);
        pin_drive_t d;
        case (t)
            PT_BIDIR:  d = '{out: lvl,  oe: ~lvl, pu: 1'b1, pd: 1'b0};
            PT_INPUT:  d = '{out: 1'b0, oe: 1'b0, pu: 1'b0, pd: 1'b0};
            PT_OUT_PU: d = '{out: lvl,  oe: 1'b1, pu: 1'b1, pd: 1'b0};
            default:   d = '{out: lvl,  oe: 1'b1, pu: 1'b0, pd: 1'b1};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/ssg_cmd_decode.sv
module ssg_cmd_decode
    import ssg_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [7:0] cmd_func,
    output pin_op_e    op
);

    always_comb begin
        op = decode_func(cmd_valid, cmd_func);
    end

endmodule

// File: rtl/ssg_regs.sv
module ssg_regs
    import ssg_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int BUF_AW   = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  pin_op_e               op,
    input  logic [BYTE_W-1:0]     cmd_data,
    input  logic [NUM_PINS-1:0]   pin_in,
    output logic [NUM_PINS-1:0]   role_gpio,
    output logic [2*NUM_PINS-1:0] type_cfg,
    output logic [NUM_PINS-1:0]   out_lvl,
    output logic                  cmd_done,
    output logic                  buf_wr_en,
    output logic [BUF_AW-1:0]     buf_wr_addr,
    output logic [BYTE_W-1:0]     buf_wr_data
);

    localparam int CFG_W = 2 * NUM_PINS;

    logic [NUM_PINS-1:0] role_q;
    logic [CFG_W-1:0]    cfg_q;
    logic [NUM_PINS-1:0] lvl_q;
    logic                done_q;
    logic                wr_q;
    logic [BYTE_W-1:0]   wdata_q;
    logic [BYTE_W-1:0]   snap;

    always_comb begin
        snap = '0;
        snap[NUM_PINS-1:0] = pin_in & role_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            role_q  <= '0;
            cfg_q   <= '0;
            lvl_q   <= '0;
            done_q  <= 1'b0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            done_q <= (op != OP_NONE);
            wr_q   <= (op == OP_SNAP);
            case (op)
                OP_LEVEL: lvl_q   <= cmd_data[NUM_PINS-1:0];
                OP_ROLE:  role_q  <= cmd_data[NUM_PINS-1:0];
                OP_TYPE:  cfg_q   <= cmd_data[CFG_W-1:0];
                OP_SNAP:  wdata_q <= snap;
                default:  ;
            endcase
        end
    end

    assign role_gpio   = role_q;
    assign type_cfg    = cfg_q;
    assign out_lvl     = lvl_q;
    assign cmd_done    = done_q;
    assign buf_wr_en   = wr_q;
    assign buf_wr_addr = '0;
    assign buf_wr_data = wdata_q;

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (role_q == '0 && cfg_q == '0 && lvl_q == '0)); // R1

    AST_ROLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op != OP_ROLE) |=> $stable(role_q)); // R2

    AST_TYPE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op != OP_TYPE) |=> $stable(cfg_q)); // R3

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op != OP_LEVEL) |=> $stable(lvl_q)); // R5

    AST_SNAP_UPPER: assert property (@(posedge clk) disable iff (rst)
        wr_q |-> (wdata_q[BYTE_W-1:NUM_PINS] == '0)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (op == OP_NONE) |=> !done_q); // R8

    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (op != OP_SNAP) |=> !wr_q); // R9

endmodule

// File: rtl/ssg_pin_mux.sv
module ssg_pin_mux
    import ssg_pkg::*;
#(
    parameter int NUM_PINS = 4
) (
    input  logic [NUM_PINS-1:0]   role_gpio,
    input  logic [2*NUM_PINS-1:0] type_cfg,
    input  logic [NUM_PINS-1:0]   out_lvl,
    input  logic [NUM_PINS-1:0]   spi_sel_n,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic [NUM_PINS-1:0]   pin_oe,
    output logic [NUM_PINS-1:0]   pin_pu,
    output logic [NUM_PINS-1:0]   pin_pd
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pin_drive_t gp;
        pin_drive_t sel;
        pin_drive_t fin;

        always_comb begin
            gp  = gpio_drive(pin_type_e'(type_cfg[2*i +: 2]), out_lvl[i]);
            sel = '{out: spi_sel_n[i], oe: 1'b1, pu: 1'b0, pd: 1'b0};
            fin = role_gpio[i] ? gp : sel;
        end

        assign pin_out[i] = fin.out;
        assign pin_oe[i]  = fin.oe;
        assign pin_pu[i]  = fin.pu;
        assign pin_pd[i]  = fin.pd;
    end

endmodule

// File: rtl/ssg_pin_ctrl.sv
module ssg_pin_ctrl
    import ssg_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int BUF_AW   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [7:0]          cmd_func,
    input  logic [7:0]          cmd_data,
    output logic                cmd_done,
    input  logic [NUM_PINS-1:0] spi_sel_n,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_pu,
    output logic [NUM_PINS-1:0] pin_pd,
    output logic                buf_wr_en,
    output logic [BUF_AW-1:0]   buf_wr_addr,
    output logic [7:0]          buf_wr_data
);

    localparam int CFG_W = 2 * NUM_PINS;

    pin_op_e             op;
    logic [NUM_PINS-1:0] role_gpio;
    logic [CFG_W-1:0]    type_cfg;
    logic [NUM_PINS-1:0] out_lvl;

    ssg_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_func  (cmd_func),
        .op        (op)
    );

    ssg_regs #(.NUM_PINS(NUM_PINS), .BUF_AW(BUF_AW)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .op          (op),
        .cmd_data    (cmd_data),
        .pin_in      (pin_in),
        .role_gpio   (role_gpio),
        .type_cfg    (type_cfg),
        .out_lvl     (out_lvl),
        .cmd_done    (cmd_done),
        .buf_wr_en   (buf_wr_en),
        .buf_wr_addr (buf_wr_addr),
        .buf_wr_data (buf_wr_data)
    );

    ssg_pin_mux #(.NUM_PINS(NUM_PINS)) u_mux (
        .role_gpio (role_gpio),
        .type_cfg  (type_cfg),
        .out_lvl   (out_lvl),
        .spi_sel_n (spi_sel_n),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pin_pu    (pin_pu),
        .pin_pd    (pin_pd)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        AST_SEL_PASS: assert property (@(posedge clk) disable iff (rst)
            !role_gpio[i] |-> (pin_out[i] == spi_sel_n[i] && pin_oe[i] && !pin_pu[i] && !pin_pd[i])); // R6

        AST_INPUT_NO_OE: assert property (@(posedge clk) disable iff (rst)
            (role_gpio[i] && type_cfg[2*i +: 2] == 2'b01) |-> !pin_oe[i]); // R4

        AST_PULL_EXCL: assert property (@(posedge clk) disable iff (rst)
            !(pin_pu[i] && pin_pd[i])); // R4
    end

endmodule

// File: tb/tb_ssg_pin_ctrl.sv
module tb_ssg_pin_ctrl;

    localparam int N  = 4;
    localparam int AW = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         cmd_valid;
    logic [7:0]   cmd_func;
    logic [7:0]   cmd_data;
    logic         cmd_done;
    logic [N-1:0] spi_sel_n;
    logic [N-1:0] pin_in;
    logic [N-1:0] pin_out, pin_oe, pin_pu, pin_pd;
    logic         buf_wr_en;
    logic [AW-1:0] buf_wr_addr;
    logic [7:0]   buf_wr_data;

    always #10 clk = ~clk;

    ssg_pin_ctrl #(.NUM_PINS(N), .BUF_AW(AW)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
        .cmd_data(cmd_data), .cmd_done(cmd_done), .spi_sel_n(spi_sel_n),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
        .pin_pd(pin_pd), .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr),
        .buf_wr_data(buf_wr_data)
    );

    typedef struct {
        bit       has_wr;
        bit [7:0] data;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   finished = 1'b0;

    bit [N-1:0]   m_role;
    bit [2*N-1:0] m_cfg;
    bit [N-1:0]   m_lvl;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Monitor: pops one expected item per completion pulse.
    always @(negedge clk) begin
        if (!rst && (cmd_done || buf_wr_en)) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R9 actual=done:%b wr:%b expected=none", cmd_done, buf_wr_en);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (!cmd_done || buf_wr_en !== e.has_wr) begin
                    fails++;
                    $display("FAIL R8 actual=done:%b wr:%b expected=done:1 wr:%b",
                             cmd_done, buf_wr_en, e.has_wr);
                end
                if (e.has_wr) begin
                    chk("R7 data", {24'd0, buf_wr_data}, {24'd0, e.data});
                    chk("R7 addr", {24'd0, buf_wr_addr}, 32'd0);
                end
            end
        end
    end

    task automatic check_pins(input string req);
        bit [N-1:0] eo, ee, eu, ed;
        for (int i = 0; i < N; i++) begin
            if (!m_role[i]) begin
                eo[i] = spi_sel_n[i]; ee[i] = 1'b1; eu[i] = 1'b0; ed[i] = 1'b0;
            end else begin
                case (m_cfg[2*i +: 2])
                    2'b00: begin eo[i] = m_lvl[i]; ee[i] = !m_lvl[i]; eu[i] = 1'b1; ed[i] = 1'b0; end
                    2'b01: begin eo[i] = 1'b0;     ee[i] = 1'b0;      eu[i] = 1'b0; ed[i] = 1'b0; end
                    2'b10: begin eo[i] = m_lvl[i]; ee[i] = 1'b1;      eu[i] = 1'b1; ed[i] = 1'b0; end
                    default: begin eo[i] = m_lvl[i]; ee[i] = 1'b1;    eu[i] = 1'b0; ed[i] = 1'b1; end
                endcase
            end
        end
        chk({req, " out"}, {28'd0, pin_out}, {28'd0, eo});
        chk({req, " oe"},  {28'd0, pin_oe},  {28'd0, ee});
        chk({req, " pu"},  {28'd0, pin_pu},  {28'd0, eu});
        chk({req, " pd"},  {28'd0, pin_pd},  {28'd0, ed});
    endtask

    // Driver: presents one command, records the expected result, then
    // confirms the pulse has gone one cycle later (R8).
    task automatic send(input bit [7:0] fid, input bit [7:0] data);
        exp_t e;
        bit known;
        known = (fid == 8'hF4 || fid == 8'hF5 || fid == 8'hF6 || fid == 8'hF7);
        if (known) begin
            e.has_wr = (fid == 8'hF5);
            e.data   = {4'd0, pin_in & m_role};
            exp_q.push_back(e);
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_func = fid; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_func = 8'h00; cmd_data = 8'h00;
        case (fid)
            8'hF4: m_lvl  = data[N-1:0];
            8'hF6: m_role = data[N-1:0];
            8'hF7: m_cfg  = data;
            default: ;
        endcase
        @(negedge clk);
        chk("R8 pulse low", {30'd0, cmd_done, buf_wr_en}, 32'd0);
    endtask

    initial begin
        #(20 * 20000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_func = '0; cmd_data = '0;
        spi_sel_n = 4'b1010; pin_in = 4'b0000;
        m_role = '0; m_cfg = '0; m_lvl = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_pins("R1 reset");
        chk("R1 done", {31'd0, cmd_done}, 32'd0);
        spi_sel_n = 4'b0101;
        #1 check_pins("R6 select follow");

        send(8'hF4, 8'h0F);
        check_pins("R5 select unaffected");
        send(8'hF6, 8'h03);
        check_pins("R2 role mask");
        send(8'hF7, 8'h1E);
        check_pins("R3 type codes");
        send(8'hF6, 8'h0F);
        check_pins("R4 all types");
        send(8'hF4, 8'h05);
        check_pins("R5 levels");
        send(8'hF4, 8'hFA);
        check_pins("R4 levels inverted");

        pin_in = 4'b1011;
        send(8'hF5, 8'hAA);
        check_pins("R7 pins unchanged");
        send(8'hF6, 8'h06);
        pin_in = 4'b1111;
        send(8'hF5, 8'h00);
        check_pins("R6 mixed roles");

        send(8'hF3, 8'hFF);
        check_pins("R9 F3 ignored");
        send(8'h01, 8'h00);
        check_pins("R9 01h ignored");
        send(8'hF8, 8'h0F);
        check_pins("R9 F8 ignored");
        spi_sel_n = 4'b1001;
        #1 check_pins("R6 select after ignored");

        send(8'hF7, 8'h00);
        check_pins("R3 back to bidirectional");

        repeat (2) @(negedge clk);
        chk("R8 queue drained", exp_q.size(), 32'd0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule